// File: doc/BRIEF.md
# Paged Effective Address Generator

This block forms the final memory address for each operand or branch target of a small processor whose 15-bit address space is divided into four 8 KB pages. The decoder presents one request at a time. Each request carries:

- an instruction class;
- the 16-bit address field taken from the instruction;
- the address of the next instruction;
- the value of the register that the instruction's register field names.

The block answers with a one-cycle valid pulse that carries the address. The pulse can also carry a write-back request for the index register.

The address field is overloaded. Its top bit asks for one level of indirection. For absolute data accesses, the two bits under it pick an index mode, and the low 13 bits are an offset within the current page. A 2-bit page register supplies the two upper address bits. Only an absolute branch carries a full 15-bit target, and finishing one loads the page register from that target. When indirection is requested, the block holds a read request toward memory with the pointer address. It waits for the returned 15-bit word before it finishes. Any index is added after the pointer has been followed.

Control is one state machine with three states:

- ST_IDLE: accepts a request. It goes to ST_DONE for a direct request and to ST_PTR for an indirect one.
- ST_PTR: holds the read request. It goes to ST_DONE when the returned word is marked valid.
- ST_DONE: presents the result for one cycle. It always returns to ST_IDLE.

Top module: `paged_ea_gen`

## Requirements
- R1: After reset the page register is 0, and `ea_valid`, `ind_req` and `idx_wr` are 0.
- R2: For class 0 (absolute data) with bit 15 clear and index mode 00, the result is {page register, field[12:0]}. The page register is unchanged. Class 3 behaves exactly as class 0.
- R3: For absolute data, field[14:13] selects the index mode: 00 none, 01 pre-increment, 10 pre-decrement, 11 index only. The 8-bit index value (updated for 01 and 10), zero-extended, is added to bits 12:0 of the base. The sum wraps within the base's page, so bits 14:13 are kept.
- R4: `idx_wr` is 1 during the result cycle only for absolute data in modes 01 and 10. It then carries in `idx_wr_data` the register value plus one (mode 01) or minus one (mode 10), modulo 256. For every other class and mode, `idx_wr` is 0.
- R5: When field bit 15 is set, `ind_req` rises one cycle after the request and stays high with a stable `ind_addr` until `ind_valid` is seen. The result appears in the cycle after `ind_valid`.
- R6: For indirect absolute data, `ind_addr` is {page register, field[12:0]} without the index. The index of R3 is then added to the returned word (post-indexing).
- R7: For class 1 (absolute branch), the result is field[14:0] when direct, or the returned word when indirect. The page register takes bits 14:13 of that result in the result cycle. No other class changes the page register.
- R8: For class 2 (relative), the sign-extended field[6:0] is added to bits 12:0 of the next-instruction address, wrapping within its page. This sum is the result when direct, or the pointer address when indirect. Field bits 14:7 are ignored.
- R9: `req_valid` is ignored outside ST_IDLE. A request raised while in ST_PTR or ST_DONE does not alter `ind_addr` or the pending result, and does not start a new operation.
- R10: `ea_valid` is a single-cycle pulse. A direct request produces it in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present (taken in ST_IDLE only) |
| req_class | input | 2 | 0 abs data, 1 abs branch, 2 relative, 3 as abs data |
| req_field | input | 16 | Instruction address field |
| req_next_pc | input | 15 | Address of the following instruction |
| req_index | input | 8 | Value of the named index register |
| ind_req | output | 1 | Pointer read request, held while waiting |
| ind_addr | output | 15 | Pointer location to read |
| ind_valid | input | 1 | Pointer word is valid this cycle |
| ind_data | input | 15 | Returned pointer word |
| ea_valid | output | 1 | Result valid pulse |
| ea_addr | output | 15 | Effective address |
| idx_wr | output | 1 | Index register write-back request |
| idx_wr_data | output | 8 | New index register value |
| page_out | output | 2 | Current page register |

## Verification
The assertions rely on the memory side keeping `ind_valid` low except while `ind_req` is high. They also assume that `req_class` and `req_field` are meaningful whenever `req_valid` is high in ST_IDLE. The stimulus raises `ind_valid` only after `ind_req` has been observed high, and drops it right after the handshake. It deliberately raises `req_valid` during ST_PTR and ST_DONE to exercise R9. A reference model in the bench tracks the page register and predicts the pointer address, result, write-back and page for directed corner cases (page wrap, index 0 and 255, negative displacement) and for a long run of pseudo-random requests with random wait lengths.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [1:0] {
        CLS_ABS_DATA = 2'd0,
        CLS_ABS_BR   = 2'd1,
        CLS_REL      = 2'd2,
        CLS_RSVD     = 2'd3
    } ea_cls_e;

    typedef enum logic [1:0] {
        IDX_NONE = 2'd0,
        IDX_INC  = 2'd1,
        IDX_DEC  = 2'd2,
        IDX_ONLY = 2'd3
    } idx_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PTR  = 2'd1,
        ST_DONE = 2'd2
    } ea_state_e;

    function automatic logic is_data_cls(ea_cls_e c);
        return (c == CLS_ABS_DATA) || (c == CLS_RSVD);
    endfunction

endpackage

// File: rtl/ea_index_unit.sv
module ea_index_unit
    import ea_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  idx_mode_e         mode,
    input  logic [DATA_W-1:0] idx_in,
    output logic [DATA_W-1:0] idx_eff,
    output logic              idx_upd
);
    always_comb begin
        unique case (mode)
            IDX_INC: begin
                idx_eff = idx_in + DATA_W'(1);
                idx_upd = 1'b1;
            end
            IDX_DEC: begin
                idx_eff = idx_in - DATA_W'(1);
                idx_upd = 1'b1;
            end
            IDX_ONLY: begin
                idx_eff = idx_in;
                idx_upd = 1'b0;
            end
            default: begin
                idx_eff = idx_in;
                idx_upd = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ea_page_add.sv
module ea_page_add #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 2,
    parameter int OFS_W  = ADDR_W - PAGE_W
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] sum
);
    logic [OFS_W-1:0] low_sum;
    assign low_sum = base[OFS_W-1:0] + ofs;
    assign sum     = {base[ADDR_W-1 -: PAGE_W], low_sum};
endmodule

// File: rtl/ea_page_reg.sv
module ea_page_reg #(
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] din,
    output logic [PAGE_W-1:0] page
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            page <= '0;
        else if (load)
            page <= din;
    end

    assert_page_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(page));
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen
    import ea_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 2,
    parameter int DATA_W = 8,
    parameter int DISP_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_class,
    input  logic [ADDR_W:0]   req_field,
    input  logic [ADDR_W-1:0] req_next_pc,
    input  logic [DATA_W-1:0] req_index,
    output logic              ind_req,
    output logic [ADDR_W-1:0] ind_addr,
    input  logic              ind_valid,
    input  logic [ADDR_W-1:0] ind_data,
    output logic              ea_valid,
    output logic [ADDR_W-1:0] ea_addr,
    output logic              idx_wr,
    output logic [DATA_W-1:0] idx_wr_data,
    output logic [PAGE_W-1:0] page_out
);
    localparam int OFS_W   = ADDR_W - PAGE_W;
    localparam int IND_BIT = ADDR_W;

    ea_state_e         state_q, state_d;
    ea_cls_e           cls_q, in_cls, sel_cls;
    idx_mode_e         mode_q, in_mode, sel_mode, use_mode;
    logic [DATA_W-1:0] idx_q, sel_idx, idx_eff;
    logic              idx_upd, ind_q, in_ind;
    logic [ADDR_W-1:0] ptr_q, ea_q, direct_base, sel_base, rel_sum, idx_sum, final_ea;
    logic              wr_q;
    logic [DATA_W-1:0] wr_data_q;
    logic              take, finish, page_load;

    // request decode
    assign in_cls  = ea_cls_e'(req_class);
    assign in_mode = idx_mode_e'(req_field[ADDR_W-1 -: 2]);
    assign in_ind  = req_field[IND_BIT];
    assign take    = (state_q == ST_IDLE) && req_valid;
    assign finish  = (take && !in_ind) || ((state_q == ST_PTR) && ind_valid);

    ea_page_add #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) rel_add_i (
        .base (req_next_pc),
        .ofs  ({{(OFS_W-DISP_W){req_field[DISP_W-1]}}, req_field[DISP_W-1:0]}),
        .sum  (rel_sum)
    );

    always_comb begin
        unique case (in_cls)
            CLS_ABS_BR: direct_base = req_field[ADDR_W-1:0];
            CLS_REL:    direct_base = rel_sum;
            default:    direct_base = {page_out, req_field[OFS_W-1:0]};
        endcase
    end

    // operand selection: live request in ST_IDLE, latched copy afterwards
    assign sel_cls  = (state_q == ST_IDLE) ? in_cls      : cls_q;
    assign sel_mode = (state_q == ST_IDLE) ? in_mode     : mode_q;
    assign sel_idx  = (state_q == ST_IDLE) ? req_index   : idx_q;
    assign sel_base = (state_q == ST_IDLE) ? direct_base : ind_data;
    assign use_mode = is_data_cls(sel_cls) ? sel_mode : IDX_NONE;

    ea_index_unit #(.DATA_W(DATA_W)) idx_i (
        .mode    (use_mode),
        .idx_in  (sel_idx),
        .idx_eff (idx_eff),
        .idx_upd (idx_upd)
    );

    ea_page_add #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) idx_add_i (
        .base (sel_base),
        .ofs  ({{(OFS_W-DATA_W){1'b0}}, idx_eff}),
        .sum  (idx_sum)
    );

    assign final_ea  = (use_mode == IDX_NONE) ? sel_base : idx_sum;
    assign page_load = finish && (sel_cls == CLS_ABS_BR);

    ea_page_reg #(.PAGE_W(PAGE_W)) page_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (page_load),
        .din   (final_ea[ADDR_W-1 -: PAGE_W]),
        .page  (page_out)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = in_ind ? ST_PTR : ST_DONE;
            ST_PTR:  if (ind_valid) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q     <= CLS_ABS_DATA;
            mode_q    <= IDX_NONE;
            idx_q     <= '0;
            ind_q     <= 1'b0;
            ptr_q     <= '0;
            ea_q      <= '0;
            wr_q      <= 1'b0;
            wr_data_q <= '0;
        end else begin
            if (take) begin
                cls_q  <= in_cls;
                mode_q <= in_mode;
                idx_q  <= req_index;
                ind_q  <= in_ind;
                ptr_q  <= direct_base;
            end
            if (finish) begin
                ea_q      <= final_ea;
                wr_q      <= idx_upd;
                wr_data_q <= idx_eff;
            end
        end
    end

    // outputs
    always_comb begin
        ind_req     = (state_q == ST_PTR);
        ind_addr    = ptr_q;
        ea_valid    = (state_q == ST_DONE);
        ea_addr     = ea_q;
        idx_wr      = (state_q == ST_DONE) && wr_q;
        idx_wr_data = wr_data_q;
    end

    assert_ptr_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ind_req && !ind_valid |=> ind_req && $stable(ind_addr));
    assert_ptr_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ind_req && ind_valid |=> ea_valid);
    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |=> !ea_valid);
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |=> !ind_req);
    assert_wr_in_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |-> ea_valid && is_data_cls(cls_q));
    assert_data_in_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid && is_data_cls(cls_q) && !ind_q |-> ea_addr[ADDR_W-1 -: PAGE_W] == page_out);
    assert_page_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(page_out) |-> ea_valid && (cls_q == CLS_ABS_BR));
endmodule

// File: tb/paged_ea_gen_tb_top.sv
`timescale 1ns/1ps
module paged_ea_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_class = '0;
    logic [15:0] req_field = '0;
    logic [14:0] req_next_pc = '0;
    logic [7:0]  req_index = '0;
    logic        ind_req;
    logic [14:0] ind_addr;
    logic        ind_valid = 1'b0;
    logic [14:0] ind_data = '0;
    logic        ea_valid;
    logic [14:0] ea_addr;
    logic        idx_wr;
    logic [7:0]  idx_wr_data;
    logic [1:0]  page_out;

    int total = 0;
    int bad = 0;
    int m_page = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    paged_ea_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
        .req_field(req_field), .req_next_pc(req_next_pc), .req_index(req_index),
        .ind_req(ind_req), .ind_addr(ind_addr), .ind_valid(ind_valid),
        .ind_data(ind_data), .ea_valid(ea_valid), .ea_addr(ea_addr),
        .idx_wr(idx_wr), .idx_wr_data(idx_wr_data), .page_out(page_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one request through the block; model computes everything from the requirements
    task automatic xfer(input int cls, input int field, input int pc, input int idx,
                        input int wait_n, input int word, input bit poke);
        int mode, disp, base, tgt, eff, fin;
        bit ind, is_data, exp_wr;
        string tag;
        mode    = (field >> 13) & 3;
        ind     = field[15];
        is_data = (cls == 0) || (cls == 3);
        tag     = is_data ? "R2/R3" : (cls == 1) ? "R7" : "R8";
        if (is_data) base = (m_page << 13) | (field & 'h1FFF);
        else if (cls == 1) base = field & 'h7FFF;
        else begin
            disp = field & 'h7F;
            if (disp >= 64) disp -= 128;
            base = (pc & 'h6000) | ((pc + disp) & 'h1FFF);
        end
        req_valid = 1'b1; req_class = cls[1:0]; req_field = field[15:0];
        req_next_pc = pc[14:0]; req_index = idx[7:0];
        @(negedge clk);
        req_valid = 1'b0;
        if (ind) begin
            check("R5 ind_req", ind_req, 1);
            check("R6 ind_addr", ind_addr, base);
            check("R5 no early result", ea_valid, 0);
            for (int w = 0; w < wait_n; w++) begin
                if (poke) begin
                    req_valid = 1'b1; req_field = 16'h0155; req_class = 2'd1;
                end
                @(negedge clk);
                req_valid = 1'b0;
                check("R9 ind_addr held", ind_addr, base);
                check("R5 ind_req held", ind_req, 1);
                check("R5 waiting", ea_valid, 0);
            end
            ind_valid = 1'b1; ind_data = word[14:0];
            @(negedge clk);
            ind_valid = 1'b0;
            tgt = word & 'h7FFF;
        end else tgt = base;
        eff = idx & 'hFF;
        if (is_data && mode == 1) eff = (idx + 1) & 'hFF;
        if (is_data && mode == 2) eff = (idx - 1) & 'hFF;
        fin = (is_data && mode != 0) ? ((tgt & 'h6000) | ((tgt + eff) & 'h1FFF)) : tgt;
        exp_wr = is_data && (mode == 1 || mode == 2);
        if (cls == 1) m_page = (fin >> 13) & 3;
        check({tag, " ea_valid R10"}, ea_valid, 1);
        check({tag, " ea_addr"}, ea_addr, fin);
        check("R4 idx_wr", idx_wr, exp_wr);
        if (exp_wr) check("R4 idx_wr_data", idx_wr_data, eff);
        check("R7 page", page_out, m_page);
        check("R5 ind_req low", ind_req, 0);
        if (poke) begin
            req_valid = 1'b1; req_class = 2'd0; req_field = 16'h8001;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 pulse end", ea_valid, 0);
        check("R9 no restart", ind_req, 0);
        check("R7 page steady", page_out, m_page);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ea_valid", ea_valid, 0);
        check("R1 ind_req", ind_req, 0);
        check("R1 idx_wr", idx_wr, 0);
        check("R1 page", page_out, 0);
        // R2 direct in page 0
        xfer(0, 'h0123, 0, 0, 0, 0, 0);
        // R7 direct branch to page 2
        xfer(1, 'h4ABC, 0, 0, 0, 0, 0);
        // R2 data now lands in page 2
        xfer(0, 'h0100, 0, 0, 0, 0, 0);
        // R3 R4 pre-increment with page wrap
        xfer(0, 'h3FFE, 0, 'h05, 0, 0, 0);
        // R3 R4 pre-decrement from zero
        xfer(0, 'h5010, 0, 'h00, 0, 0, 0);
        // R3 index only, increment from 255 wraps
        xfer(0, 'h7F80, 0, 'h80, 0, 0, 0);
        xfer(0, 'h2000, 0, 'hFF, 0, 0, 0);
        // R8 negative displacement, field bits 14:7 ignored
        xfer(2, 'h7FFF, 'h2001, 'h33, 0, 0, 0);
        // R8 forward wrap inside page
        xfer(2, 'h0001, 'h3FFF, 0, 0, 0, 0);
        // R6 R9 indirect indexed with post-indexing and busy pokes
        xfer(0, 'hE040, 0, 'h10, 3, 'h7FF8, 1);
        // R5 R7 indirect branch to page 1
        xfer(1, 'h8200, 0, 0, 1, 'h2345, 1);
        // R8 indirect relative
        xfer(2, 'h8040, 'h6100, 0, 0, 'h0777, 0);
        // R2 class 3 as data
        xfer(3, 'h2010, 0, 'h07, 0, 0, 0);
        for (int n = 0; n < 400; n++) begin
            xfer(int'($urandom_range(0, 3)), int'($urandom_range(0, 'hFFFF)),
                 int'($urandom_range(0, 'h7FFF)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 4)), int'($urandom_range(0, 'h7FFF)),
                 1'($urandom_range(0, 1)));
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule